// File: doc/BRIEF.md
# Two-Step Converter Code Combiner

This block builds the output word of a two-step (coarse then fine) conversion. A first flash stage produces a 7-bit coarse code. The block registers that code and sends the registered copy to the reconstruction DAC, which forms the residue. The residue is amplified by 32 and quantised by a second 7-bit flash stage. The block then adds the fine code to the coarse code, with the fine code overlapping the coarse one, to give a 12-bit result.

The fine code has two more bits than the 5 that one coarse step of 32 output LSBs needs. This extra range lets the addition absorb a coarse decision that is off by about one step in either direction. The result is coarse × 32 + fine − 48. The constant 48 places the fine code's midpoint range on the nominal coarse step. A sum outside 0..4095 is clamped to the nearest end of that range and flagged.

The coarse code is held in a register stage. Each fine code is therefore combined with the coarse code of its own sample, even when the next coarse code arrives in the same cycle. Each fine strobe gives a result with a fixed latency of one clock.

Top module: `subrange_corrector`

## Requirements
- R1: While reset is asserted and at the first clock after its release, `result`, `result_vld`, `ovr_lo`, `ovr_hi` and `dac_code` are all zero.
- R2: When `coarse_vld` is high at a clock edge, `dac_code` takes the value of `coarse_code` after that edge. Without the strobe, `dac_code` keeps its value.
- R3: For a fine strobe whose sum S = C*32 + F - 48 lies in 0..4095, `result` equals S. Here C is the paired coarse code and F is the fine code.
- R4: When S < 0, `result` is 0 and `ovr_lo` is 1.
- R5: When S > 4095, `result` is 4095 and `ovr_hi` is 1.
- R6: `result_vld` is high for exactly the one cycle following each clock edge at which `fine_vld` was high. This holds for back-to-back strobes too.
- R7: Between fine strobes, `result`, `ovr_lo` and `ovr_hi` keep their values, whatever `fine_code` and `coarse_code` do.
- R8: A fine code pairs with the coarse code latched at the most recent earlier coarse strobe. A coarse strobe in the same cycle as a fine strobe is used only by later fine strobes.
- R9: For an in-range sum both flags are 0, and the two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coarse_vld | input | 1 | Coarse code strobe |
| coarse_code | input | 7 | Coarse flash code |
| fine_vld | input | 1 | Fine code strobe |
| fine_code | input | 7 | Fine flash code (residue × 32) |
| dac_code | output | 7 | Registered coarse code driven to the residue DAC |
| result | output | 12 | Corrected output word |
| result_vld | output | 1 | One-cycle result strobe |
| ovr_lo | output | 1 | Sum was below zero and was clamped to 0 |
| ovr_hi | output | 1 | Sum was above full scale and was clamped to 4095 |

## Verification
Every pair of coarse and fine codes, 128 × 128 in all, goes through the block as a coarse strobe followed by a fine strobe. This sweep separates the in-range addition from the low clamp (small coarse codes with fine codes under 48) and from the high clamp (top coarse codes with large fine codes). It also checks the DAC copy of each coarse code. A coincident coarse and fine strobe shows whether pairing uses the delayed coarse register rather than the live input. Back-to-back fine strobes on one coarse code test the one-cycle latency and the strobe count. Idle cycles with changing codes show that the output holds.

// File: rtl/subrange_corrector.sv
module subrange_corrector #(
  parameter int CW     = 7,
  parameter int FW     = 7,
  parameter int OW     = 12,
  parameter int SHIFT  = 5,
  parameter int OFFSET = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          coarse_vld,
  input  logic [CW-1:0] coarse_code,
  input  logic          fine_vld,
  input  logic [FW-1:0] fine_code,
  output logic [CW-1:0] dac_code,
  output logic [OW-1:0] result,
  output logic          result_vld,
  output logic          ovr_lo,
  output logic          ovr_hi
);

  localparam int TW = (CW + SHIFT > FW) ? CW + SHIFT : FW;
  localparam int SW = TW + 2;
  localparam logic [SW-1:0] FULL = SW'((1 << OW) - 1);

  logic [CW-1:0] coarse_q;
  logic [SW-1:0] sum_w;
  logic          neg_w, big_w;

  assign sum_w = (SW'(coarse_q) << SHIFT) + SW'(fine_code) - SW'(OFFSET);
  assign neg_w = sum_w[SW-1];
  assign big_w = !neg_w && (sum_w > FULL);
  assign dac_code = coarse_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      coarse_q <= '0;
    else if (coarse_vld)
      coarse_q <= coarse_code;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result     <= '0;
      result_vld <= 1'b0;
      ovr_lo     <= 1'b0;
      ovr_hi     <= 1'b0;
    end else begin
      result_vld <= fine_vld;
      if (fine_vld) begin
        ovr_lo <= neg_w;
        ovr_hi <= big_w;
        if (neg_w)      result <= '0;
        else if (big_w) result <= '1;
        else            result <= sum_w[OW-1:0];
      end
    end
  end

  p_dac_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_vld |=> dac_code == $past(coarse_code));
  p_dac_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !coarse_vld |=> $stable(dac_code));
  p_vld_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fine_vld |=> result_vld);
  p_vld_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fine_vld |=> !result_vld);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fine_vld |=> ($stable(result) && $stable(ovr_lo) && $stable(ovr_hi)));
  p_lo_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_lo |-> result == '0);
  p_hi_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_hi |-> result == '1);
  p_flag_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovr_lo && ovr_hi));

endmodule

// File: tb/subrange_corrector_tb.sv
module subrange_corrector_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       coarse_vld = 1'b0;
  logic [6:0] coarse_code = '0;
  logic       fine_vld = 1'b0;
  logic [6:0] fine_code = '0;
  logic [6:0] dac_code;
  logic [11:0] result;
  logic       result_vld, ovr_lo, ovr_hi;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  subrange_corrector u_dut (
    .clk(clk), .rst_n(rst_n),
    .coarse_vld(coarse_vld), .coarse_code(coarse_code),
    .fine_vld(fine_vld), .fine_code(fine_code),
    .dac_code(dac_code), .result(result), .result_vld(result_vld),
    .ovr_lo(ovr_lo), .ovr_hi(ovr_hi)
  );

  function automatic int raw_sum(int c, int f);
    return c * 32 + f - 48;
  endfunction

  function automatic int clamp(int s);
    if (s < 0) return 0;
    if (s > 4095) return 4095;
    return s;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_result(string req, int c, int f);
    int s = raw_sum(c, f);
    chk(req, result_vld, 1);
    chk(req, result, clamp(s));
    chk(req, ovr_lo, (s < 0) ? 1 : 0);
    chk(req, ovr_hi, (s > 4095) ? 1 : 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", result, 0); chk("R1", result_vld, 0);
    chk("R1", ovr_lo, 0); chk("R1", ovr_hi, 0); chk("R1", dac_code, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", result_vld, 0); chk("R1", result, 0); chk("R1", dac_code, 0);

    // exhaustive sweep: R2, R3, R4, R5, R9
    for (int c = 0; c < 128; c++) begin
      for (int f = 0; f < 128; f++) begin
        coarse_vld = 1'b1; coarse_code = 7'(c); fine_vld = 1'b0;
        @(negedge clk);
        chk("R2", dac_code, c);
        coarse_vld = 1'b0; coarse_code = 7'(127 - c);
        fine_vld = 1'b1; fine_code = 7'(f);
        @(negedge clk);
        fine_vld = 1'b0;
        if (raw_sum(c, f) < 0)          chk_result("R4", c, f);
        else if (raw_sum(c, f) > 4095)  chk_result("R5", c, f);
        else                            chk_result("R3/R9", c, f);
      end
    end

    // R7: idle cycles with moving codes, output holds (last pair 127,127)
    for (int k = 0; k < 4; k++) begin
      fine_code = 7'(k * 17); coarse_code = 7'(k * 29);
      @(negedge clk);
      chk("R7 vld", result_vld, 0);
      chk("R7 result", result, 4095);
      chk("R7 flag", ovr_hi, 1);
      chk("R2 hold", dac_code, 127);
    end

    // R8: coarse strobe coinciding with fine strobe
    coarse_vld = 1'b1; coarse_code = 7'd10;
    @(negedge clk);
    coarse_vld = 1'b1; coarse_code = 7'd50;
    fine_vld = 1'b1; fine_code = 7'd60;
    @(negedge clk);
    coarse_vld = 1'b0; fine_vld = 1'b0;
    chk_result("R8 old coarse", 10, 60);
    fine_vld = 1'b1; fine_code = 7'd5;
    @(negedge clk);
    fine_vld = 1'b0;
    chk_result("R8 new coarse", 50, 5);

    // R6: back-to-back fine strobes
    fine_vld = 1'b1; fine_code = 7'd0;
    @(negedge clk);
    chk_result("R6 first", 50, 0);
    fine_code = 7'd100;
    @(negedge clk);
    chk_result("R6 second", 50, 100);
    fine_vld = 1'b0;
    @(negedge clk);
    chk("R6 drop", result_vld, 0);
    chk("R7 keep", result, 50 * 32 + 100 - 48);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule